// File: doc/BRIEF.md
# Class-D Power Stage Fault Manager

This block is the digital fault controller that sits beside a four-half-bridge class-D output stage. Comparator flags arrive from the analog side without any clock relationship. These flags report supply undervoltage, the temperature warning, thermal shutdown, per-channel current limiting, per-channel latched overcurrent, per-channel bootstrap undervoltage and per-channel PWM presence. The block first passes every flag through two synchronising flops. It then decides which half-bridges must stop switching and drives three enables for each half-bridge: high side, low side and Hi-Z. It also drives two active-low status outputs, one for faults and one for the temperature warning.

The output-mode select chooses how a channel fault spreads to the other channels. In the two bridged modes, channels shut down in pairs or all four together. In the single-ended mode, a fault on the first channel of a pair also stops its partner. Some faults clear as soon as their cause goes away. Others stay latched until the external active-low restart input is released. The block honours that release only when enough time has passed since the fault output fell. A release that comes too early is ignored and sets a sticky flag. Two time limits are derived from the `CLK_KHZ` parameter: the 2.6 ms persistence limit for current limiting and the 4 ms restart guard.

Top module: `ampfault_ctrl`

## Requirements
- R1: While the restart input `amp_rst_n_i` is low, after the two-flop synchroniser delay, all four half-bridges are Hi-Z with both switch enables low, and `fault_n_o` is high whatever faults are present. After the synchronous reset `rst`, the same state holds, `otw_n_o` is high and `early_rst_o` is low.
- R2: With mode 2'b00 (bridged pairs), a channel fault on half-bridge 0 or 1 sets Hi-Z on bits 0 and 1, and a channel fault on half-bridge 2 or 3 sets Hi-Z on bits 2 and 3.
- R3: With mode 2'b01 (paralleled bridge), a channel fault on any half-bridge sets all four Hi-Z. Mode 2'b11 behaves the same way.
- R4: With mode 2'b10 (single-ended), a fault on bit 0 stops bits 0 and 1, a fault on bit 1 stops only bit 1, a fault on bit 2 stops bits 2 and 3, and a fault on bit 3 stops only bit 3.
- R5: Thermal shutdown (`ots_i`) sets all four half-bridges Hi-Z and drives `fault_n_o` and `otw_n_o` low. The condition stays latched after the flag drops and is cleared only by an honoured restart.
- R6: Supply undervoltage (`uv_i`) sets all four half-bridges Hi-Z and drives `fault_n_o` low while `otw_n_o` stays high. It clears by itself when the flag drops, with no restart.
- R7: A latched-overcurrent flag on a channel shuts down that channel's group (as in R2 to R4), drives `fault_n_o` low, and stays latched until an honoured restart.
- R8: Current limiting (`cbc_i`) does not by itself stop a channel. If the flag stays high for OLP_CYC = CLK_KHZ*26/10 consecutive cycles, nothing latches. If it stays high for one more cycle, an overload latches on that channel with the same effect as R7.
- R9: Bootstrap undervoltage on a half-bridge clears only that half-bridge's high-side enable. Its low-side enable stays high, it is not Hi-Z, `fault_n_o` stays high, and the condition clears by itself.
- R10: When PWM is lost (`pwm_ok_i` bit low) on one to three channels, their groups go Hi-Z per R2 to R4. When PWM is lost on all four channels, all four go Hi-Z. In both cases `fault_n_o` stays high, and the outputs recover when PWM returns.
- R11: A temperature warning (`otw_i`) alone drives `otw_n_o` low. It does not latch, stops no channel, and leaves `fault_n_o` high.
- R12: A rising edge of `amp_rst_n_i` that comes less than GUARD_CYC = CLK_KHZ*4 cycles after `fault_n_o` fell is ignored. The channels stay Hi-Z, latched faults are kept, and `early_rst_o` is set and stays set until `rst`. A rising edge that comes later restarts the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_rst_n_i | input | 1 | Active-low restart request, asynchronous |
| mode_i | input | 2 | Output mode: 00 bridged pairs, 01 paralleled, 10 single-ended, 11 as 01 |
| uv_i | input | 1 | Supply undervoltage or power-on reset flag |
| otw_i | input | 1 | Temperature warning flag |
| ots_i | input | 1 | Thermal shutdown flag |
| cbc_i | input | 4 | Per-channel current-limiting flag |
| ocl_i | input | 4 | Per-channel latched-overcurrent flag |
| bst_uv_i | input | 4 | Per-channel bootstrap undervoltage flag |
| pwm_ok_i | input | 4 | Per-channel PWM present (1) or lost (0) |
| hs_en_o | output | 4 | High-side switch enable per half-bridge |
| ls_en_o | output | 4 | Low-side switch enable per half-bridge |
| hiz_o | output | 4 | Hi-Z enable per half-bridge |
| fault_n_o | output | 1 | Active-low fault output |
| otw_n_o | output | 1 | Active-low temperature warning output |
| early_rst_o | output | 1 | Sticky flag: a restart was refused by the guard |

## Verification
The bench sweeps every nonzero PWM-loss mask in each of the three modes. A wrong group table would stop the wrong partner, for example leaving bit 1 live after a bit-0 fault in single-ended mode. The current-limiting flag is held for exactly the limit and then for one cycle more, so an off-by-one persistence counter either latches too soon or misses the latch. The bench issues one restart inside the guard window and one outside it. A design that ignores the guard would clear the thermal latch too early, and one that misplaces the window would refuse the valid restart. The bench also confirms that a latched fault survives the removal of its flag, and that undervoltage and bootstrap faults recover without a restart.

// File: rtl/ampfault_pkg.sv
package ampfault_pkg;

    localparam int NCH = 4;

    typedef enum logic [1:0] {
        MODE_BTL  = 2'b00,
        MODE_PBTL = 2'b01,
        MODE_SE   = 2'b10,
        MODE_RSV  = 2'b11
    } out_mode_e;

    // Synchronised view of all asynchronous flag inputs
    typedef struct packed {
        logic           rst_n;
        logic           uv;
        logic           otw;
        logic           ots;
        logic [NCH-1:0] cbc;
        logic [NCH-1:0] ocl;
        logic [NCH-1:0] bst_uv;
        logic [NCH-1:0] pwm_ok;
    } flags_t;

    typedef struct packed {
        logic [NCH-1:0] hs;
        logic [NCH-1:0] ls;
        logic [NCH-1:0] hiz;
    } bridge_ctl_t;

    // Spread per-channel faults to the channels they stop, per mode
    function automatic logic [NCH-1:0] group_off(out_mode_e m, logic [NCH-1:0] f);
        logic [NCH-1:0] r;
        case (m)
            MODE_BTL: begin
                r[1:0] = {2{f[0] | f[1]}};
                r[3:2] = {2{f[2] | f[3]}};
            end
            MODE_SE: begin
                r[0] = f[0];
                r[1] = f[0] | f[1];
                r[2] = f[2];
                r[3] = f[2] | f[3];
            end
            default: r = {NCH{|f}};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/afc_ocp_timer.sv
module afc_ocp_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cbc,
    input  logic ocl,
    input  logic clr,
    output logic olp
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          lat;
    logic          esc;

    assign esc = cbc && (cnt == LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lat <= 1'b0;
        end else begin
            if (!cbc)
                cnt <= '0;
            else if (cnt != LIM)
                cnt <= cnt + 1'b1;
            lat <= ocl | esc | (lat & ~clr);
        end
    end

    assign olp = lat | ocl | esc;
endmodule

// File: rtl/afc_restart_guard.sv
module afc_restart_guard #(
    parameter int GUARD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_n,
    input  logic rise,
    output logic honour,
    output logic early
);
    localparam int GW = $clog2(GUARD + 1);
    localparam logic [GW-1:0] GLIM = GW'(GUARD);

    logic          fault_q;
    logic [GW-1:0] cnt;

    assign honour = rise && (cnt == GLIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b1;
            cnt     <= GLIM;
            early   <= 1'b0;
        end else begin
            fault_q <= fault_n;
            if (fault_q && !fault_n)
                cnt <= '0;
            else if (cnt != GLIM)
                cnt <= cnt + 1'b1;
            if (rise && !honour)
                early <= 1'b1;
        end
    end
endmodule

// File: rtl/ampfault_ctrl.sv
module ampfault_ctrl
    import ampfault_pkg::*;
#(
    parameter int CLK_KHZ = 125000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           amp_rst_n_i,
    input  logic [1:0]     mode_i,
    input  logic           uv_i,
    input  logic           otw_i,
    input  logic           ots_i,
    input  logic [NCH-1:0] cbc_i,
    input  logic [NCH-1:0] ocl_i,
    input  logic [NCH-1:0] bst_uv_i,
    input  logic [NCH-1:0] pwm_ok_i,
    output logic [NCH-1:0] hs_en_o,
    output logic [NCH-1:0] ls_en_o,
    output logic [NCH-1:0] hiz_o,
    output logic           fault_n_o,
    output logic           otw_n_o,
    output logic           early_rst_o
);
    localparam int OLP_CYC   = (CLK_KHZ * 26) / 10;
    localparam int GUARD_CYC = CLK_KHZ * 4;

    flags_t         raw;
    flags_t         fs;
    logic           rst_q;
    logic           rise;
    logic           restart;
    logic           running;
    logic           ots_lat;
    logic [NCH-1:0] olp;
    logic [NCH-1:0] pwm_lost;
    logic [NCH-1:0] off;
    logic           global_off;
    logic           fault_hit;
    bridge_ctl_t    ctl;

    assign raw = '{rst_n: amp_rst_n_i, uv: uv_i, otw: otw_i, ots: ots_i,
                   cbc: cbc_i, ocl: ocl_i, bst_uv: bst_uv_i, pwm_ok: pwm_ok_i};

    afc_sync #(.W($bits(flags_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (fs)
    );

    assign rise = fs.rst_n & ~rst_q;

    afc_restart_guard #(.GUARD(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .fault_n (fault_n_o),
        .rise    (rise),
        .honour  (restart),
        .early   (early_rst_o)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            afc_ocp_timer #(.LIMIT(OLP_CYC)) u_ocp (
                .clk (clk),
                .rst (rst),
                .cbc (fs.cbc[i]),
                .ocl (fs.ocl[i]),
                .clr (restart),
                .olp (olp[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q   <= 1'b0;
            running <= 1'b0;
            ots_lat <= 1'b0;
        end else begin
            rst_q   <= fs.rst_n;
            if (restart)
                running <= 1'b1;
            else if (!fs.rst_n)
                running <= 1'b0;
            ots_lat <= fs.ots | (ots_lat & ~restart);
        end
    end

    always_comb begin
        pwm_lost   = ~fs.pwm_ok;
        global_off = ~running | fs.uv | fs.ots | ots_lat | (&pwm_lost);
        off        = global_off ? {NCH{1'b1}}
                                : group_off(out_mode_e'(mode_i), olp | pwm_lost);
        ctl.hiz    = off;
        ctl.ls     = ~off;
        ctl.hs     = ~off & ~fs.bst_uv;
        fault_hit  = fs.uv | fs.ots | ots_lat | (|olp);
    end

    assign hs_en_o   = ctl.hs;
    assign ls_en_o   = ctl.ls;
    assign hiz_o     = ctl.hiz;
    assign fault_n_o = ~(rst_q & fault_hit);
    assign otw_n_o   = ~(fs.otw | fs.ots | ots_lat);
endmodule

// File: rtl/ampfault_ctrl_chk.sv
module ampfault_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       amp_rst_n_i,
    input logic [1:0] mode_i,
    input logic [3:0] hiz_o,
    input logic       fault_n_o,
    input logic       early_rst_o,
    input logic       ots_lat,
    input logic       restart
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 3'd7)
            age <= age + 1'b1;
    end

    AST_RST_FORCES_SAFE: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && !amp_rst_n_i && !$past(amp_rst_n_i) && !$past(amp_rst_n_i, 2)
         && !$past(amp_rst_n_i, 3)) |-> (hiz_o == 4'hF && fault_n_o)); // R1
    AST_BTL_PAIRS: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |-> (hiz_o[0] == hiz_o[1] && hiz_o[2] == hiz_o[3])); // R2
    AST_PBTL_ALL: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01) |-> (hiz_o == 4'h0 || hiz_o == 4'hF)); // R3
    AST_SE_LEADER: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |-> ((!hiz_o[0] || hiz_o[1]) && (!hiz_o[2] || hiz_o[3]))); // R4
    AST_OTE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ots_lat && !restart) |=> ots_lat); // R5
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
        !fault_n_o |-> (hiz_o != 4'h0)); // R6
    AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (rst)
        early_rst_o |=> early_rst_o); // R12
endmodule

bind ampfault_ctrl ampfault_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .amp_rst_n_i (amp_rst_n_i),
    .mode_i      (mode_i),
    .hiz_o       (hiz_o),
    .fault_n_o   (fault_n_o),
    .early_rst_o (early_rst_o),
    .ots_lat     (ots_lat),
    .restart     (restart)
);

// File: tb/tb_ampfault_ctrl.sv
module tb_ampfault_ctrl;
    localparam int KHZ   = 5;
    localparam int OLP   = (KHZ * 26) / 10; // 13
    localparam int GUARD = KHZ * 4;         // 20

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       amp_rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       uv = 1'b0, otw = 1'b0, ots = 1'b0;
    logic [3:0] cbc = '0, ocl = '0, bst = '0, pwm_ok = 4'hF;
    logic [3:0] hs, ls, hiz;
    logic       fault_n, otw_n, early;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ampfault_ctrl #(.CLK_KHZ(KHZ)) dut (
        .clk(clk), .rst(rst), .amp_rst_n_i(amp_rst_n), .mode_i(mode),
        .uv_i(uv), .otw_i(otw), .ots_i(ots), .cbc_i(cbc), .ocl_i(ocl),
        .bst_uv_i(bst), .pwm_ok_i(pwm_ok), .hs_en_o(hs), .ls_en_o(ls),
        .hiz_o(hiz), .fault_n_o(fault_n), .otw_n_o(otw_n), .early_rst_o(early)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected Hi-Z set for a channel-fault mask, per mode
    function automatic logic [3:0] exp_off(input logic [1:0] m, input logic [3:0] f);
        logic [3:0] r;
        if (f == 4'hF) return 4'hF;
        if (m == 2'b00)
            r = {{2{f[3] | f[2]}}, {2{f[1] | f[0]}}};
        else if (m == 2'b10)
            r = {f[3] | f[2], f[2], f[1] | f[0], f[0]};
        else
            r = (f != 0) ? 4'hF : 4'h0;
        return r;
    endfunction

    task automatic restart_long();
        amp_rst_n = 1'b0;
        step(GUARD + 10);
        amp_rst_n = 1'b1;
        step(6);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(5);
        // R1 reset state and held restart input
        chk("R1 hiz", {12'h0, hiz}, 16'hF);
        chk("R1 hs/ls", {8'h0, hs, ls}, 16'h0);
        chk("R1 flags", {13'h0, fault_n, otw_n, early}, 16'b110);
        ots = 1'b1;
        step(4);
        chk("R1 fault forced high", {15'h0, fault_n}, 16'h1);
        ots = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        amp_rst_n = 1'b1;
        step(6);
        chk("R1 running", {4'h0, hs, ls, hiz}, 16'hFF0);

        // R2 R3 R4 R10 sweep of PWM-loss masks in each mode
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m);
            for (int f = 1; f < 16; f++) begin
                pwm_ok = ~4'(f);
                step(4);
                chk(m == 0 ? "R2 R10 group" : (m == 1 ? "R3 R10 group" : "R4 R10 group"),
                    {12'h0, hiz}, {12'h0, exp_off(2'(m), 4'(f))});
                chk("R10 no fault", {15'h0, fault_n}, 16'h1);
            end
            pwm_ok = 4'hF;
            step(4);
            chk("R10 recover", {12'h0, hiz}, 16'h0);
        end
        mode = 2'b11;
        pwm_ok = 4'b1011;
        step(4);
        chk("R3 reserved mode", {12'h0, hiz}, 16'hF);
        pwm_ok = 4'hF;
        mode = 2'b00;
        step(4);

        // R7 latched overcurrent, BTL
        ocl = 4'b0100;
        step(4);
        chk("R7 group", {12'h0, hiz}, 16'hC);
        chk("R7 flags", {14'h0, fault_n, otw_n}, 16'b01);
        ocl = 4'b0000;
        step(6);
        chk("R7 latched", {12'h0, hiz}, 16'hC);
        restart_long();
        chk("R7 cleared", {11'h0, fault_n, hiz}, 16'h10);

        // R6 undervoltage self-clearing
        uv = 1'b1;
        step(4);
        chk("R6 active", {10'h0, fault_n, otw_n, hiz}, 16'h1F);
        uv = 1'b0;
        step(4);
        chk("R6 cleared", {10'h0, fault_n, otw_n, hiz}, 16'h30);

        // R11 warning only
        otw = 1'b1;
        step(4);
        chk("R11 warning", {10'h0, fault_n, otw_n, hiz}, 16'h20);
        otw = 1'b0;
        step(4);
        chk("R11 no latch", {15'h0, otw_n}, 16'h1);

        // R9 bootstrap undervoltage
        bst = 4'b0101;
        step(4);
        chk("R9 hs", {12'h0, hs}, 16'hA);
        chk("R9 ls/hiz/fault", {7'h0, ls, hiz, fault_n}, 16'h1E1);
        bst = 4'b0000;
        step(4);
        chk("R9 recover", {12'h0, hs}, 16'hF);

        // R8 current-limit persistence
        cbc = 4'b0010;
        step(OLP);
        cbc = 4'b0000;
        step(4);
        chk("R8 at limit", {11'h0, fault_n, hiz}, 16'h10);
        cbc = 4'b0010;
        step(8);
        chk("R8 limiting only", {12'h0, hiz}, 16'h0);
        step(OLP + 1 - 8);
        cbc = 4'b0000;
        step(4);
        chk("R8 escalated", {11'h0, fault_n, hiz}, 16'h03);
        restart_long();
        chk("R8 cleared", {11'h0, fault_n, hiz}, 16'h10);

        // R5 thermal shutdown and R12 restart guard
        ots = 1'b1;
        step(4);
        chk("R5 active", {10'h0, fault_n, otw_n, hiz}, 16'h0F);
        ots = 1'b0;
        step(4);
        chk("R5 latched", {10'h0, fault_n, otw_n, hiz}, 16'h0F);
        amp_rst_n = 1'b0;
        step(3);
        amp_rst_n = 1'b1;
        step(6);
        chk("R12 early ignored", {11'h0, fault_n, hiz}, 16'h0F);
        chk("R12 sticky set", {15'h0, early}, 16'h1);
        restart_long();
        chk("R12 late honoured", {10'h0, fault_n, otw_n, hiz}, 16'h30);
        chk("R12 sticky kept", {15'h0, early}, 16'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule